// File: doc/BRIEF.md
# Batch-Committed Word Queue with Slot Peek

This block is a 64-entry, 32-bit word queue. A producer writes the words of a batch one at a time. The written words stay hidden from the consumer until the producer pulses a commit input. The commit moves every pending word into the visible region in one cycle. As a result, once the consumer sees the first word of a batch, the rest of that batch is already readable.

The queue has no handshake at its edges:

- **Writing.** The producer pulses a push input with a data word.
- **Reading.** The consumer sees the oldest visible word on a combinational output and pulses a pop input to drop it.
- **Status.** Two 16-bit half-words are packed ready for a register readout:
  - one carries the visible count and the empty and full flags;
  - one carries the raw write and read cursors.

  When two queues share one register word, the transmit queue takes the low half and the receive queue takes the high half.
- **Clear.** A clear input empties the queue.
- **Peek.** A debug port reads any buffer slot without moving anything.

Top module: `bq_fifo`

## Requirements
- R1: After reset, the visible count is 0, the empty flag is 1, the full flag is 0, and both cursors are 0.
- R2: A pushed word is not visible until a commit. The count, the write cursor and the pop data all ignore pending words.
- R3: A commit makes every pending word visible in one cycle, including a word pushed in the same cycle. The count rises by the number of pending words.
- R4: The pop data shows the oldest visible word. A pop removes it, so words leave in the order they were pushed. The read cursor advances by one on each pop.
- R5: A pop while the visible count is 0 has the following effects in that cycle:
  - the pop data is 0;
  - the underflow output is 1;
  - the cursors and the count do not change.
- R6: Status half-word layout: bits 7:0 hold the visible count (0..64). Bit 8 is 1 exactly when the count is 0. Bit 9 is 1 exactly when the count is 64. Bits 15:10 are 0.
- R7: Cursor half-word layout: bits 7:0 hold the committed write cursor (0..63) and bits 15:8 hold the read cursor (0..63). Both cursors wrap from 63 to 0, so equal cursors mean either empty or full.
- R8: A push is dropped when visible plus pending words already total 64. A dropped word never appears at the pop data.
- R9: A clear empties the queue in the next cycle, as follows:
  - pending words are discarded;
  - both cursors return to 0;
  - a push, pop or commit in the same cycle has no effect.
- R10: The peek data shows the word stored at the selected slot. Peeking changes neither the cursors nor the count.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low asynchronous reset |
| push | input | 1 | Write pushData into the pending region |
| pushData | input | 32 | Word to write |
| commit | input | 1 | Make all pending words visible |
| pop | input | 1 | Remove the oldest visible word |
| popData | output | 32 | Oldest visible word, or 0 when empty |
| underflow | output | 1 | Pop attempted while empty |
| clear | input | 1 | Empty the queue and reset the cursors |
| peekSlot | input | 6 | Buffer slot to inspect |
| peekData | output | 32 | Word stored at peekSlot |
| statusHalf | output | 16 | Count, empty and full flags |
| cursorHalf | output | 16 | Write and read cursors |

## Verification
The assertions check several properties on every cycle:

- the visible and pending counts together never exceed the capacity;
- without a commit, the visible count never grows;
- a commit never shrinks the count unless a pop happens in the same cycle;
- a clear always leaves both counts at zero;
- an empty pop leaves the read cursor where it was;
- the empty and full flags are never both set.

Some behaviour only the bench scenarios can show:

- data order across batches;
- the exact word shown by the peek port;
- the dropped word when the queue is full;
- cursor wrap-around after 64 words;
- the precedence of clear over simultaneous operations.

// File: rtl/bq_pkg.sv
package bq_pkg;
  typedef struct packed {
    logic wrEn;     // store pushData at the shadow slot
    logic rdValid;  // read slot holds a visible word
  } bqStrobes_t;
endpackage

// File: rtl/bq_ctrl.sv
module bq_ctrl
  import bq_pkg::*;
#(
  parameter int DEPTH = 64,
  localparam int AW = $clog2(DEPTH),
  localparam int CW = $clog2(DEPTH + 1)
) (
  input  logic          clk,
  input  logic          rstN,
  input  logic          push,
  input  logic          commit,
  input  logic          pop,
  input  logic          clear,
  output bqStrobes_t    strobes,
  output logic [AW-1:0] shadowPtr,
  output logic [AW-1:0] wrPtr,
  output logic [AW-1:0] rdPtr,
  output logic [CW-1:0] visCount,
  output logic          underflow
);
  logic [CW-1:0] pendCount;
  logic          doPush, doPop;
  logic [CW-1:0] pendNext;

  always_comb begin
    doPush   = push && !clear && ((visCount + pendCount) < CW'(DEPTH));
    doPop    = pop && !clear && (visCount != '0);
    pendNext = pendCount + CW'(doPush);
  end

  assign underflow       = pop && (visCount == '0);
  assign strobes.wrEn    = doPush;
  assign strobes.rdValid = (visCount != '0);

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      shadowPtr <= '0;
      wrPtr     <= '0;
      rdPtr     <= '0;
      visCount  <= '0;
      pendCount <= '0;
    end else if (clear) begin
      shadowPtr <= '0;
      wrPtr     <= '0;
      rdPtr     <= '0;
      visCount  <= '0;
      pendCount <= '0;
    end else begin
      shadowPtr <= shadowPtr + AW'(doPush);
      rdPtr     <= rdPtr + AW'(doPop);
      if (commit) begin
        wrPtr     <= shadowPtr + AW'(doPush);
        visCount  <= visCount + pendNext - CW'(doPop);
        pendCount <= '0;
      end else begin
        visCount  <= visCount - CW'(doPop);
        pendCount <= pendNext;
      end
    end
  end

  // R8
  total_cap_chk: assert property (@(posedge clk) disable iff (!rstN)
    (CW+1)'(visCount) + (CW+1)'(pendCount) <= (CW+1)'(DEPTH));

  // R2
  no_commit_no_grow_chk: assert property (@(posedge clk) disable iff (!rstN)
    (!commit && !clear) |=> visCount <= $past(visCount));

  // R3
  commit_grows_chk: assert property (@(posedge clk) disable iff (!rstN)
    (commit && !clear && !pop) |=> visCount >= $past(visCount));

  // R9
  clear_empties_chk: assert property (@(posedge clk) disable iff (!rstN)
    clear |=> (visCount == '0) && (pendCount == '0));

  // R5
  empty_pop_stable_chk: assert property (@(posedge clk) disable iff (!rstN)
    (pop && !clear && visCount == '0) |=> rdPtr == $past(rdPtr));
endmodule

// File: rtl/bq_data.sv
module bq_data
  import bq_pkg::*;
#(
  parameter int DEPTH = 64,
  parameter int WIDTH = 32,
  localparam int AW = $clog2(DEPTH)
) (
  input  logic             clk,
  input  bqStrobes_t       strobes,
  input  logic [AW-1:0]    wrAddr,
  input  logic [WIDTH-1:0] wrData,
  input  logic [AW-1:0]    rdAddr,
  input  logic [AW-1:0]    peekAddr,
  output logic [WIDTH-1:0] rdData,
  output logic [WIDTH-1:0] peekData
);
  logic [WIDTH-1:0] mem [DEPTH];

  always_ff @(posedge clk) begin
    if (strobes.wrEn) mem[wrAddr] <= wrData;
  end

  assign rdData   = strobes.rdValid ? mem[rdAddr] : '0;
  assign peekData = mem[peekAddr];
endmodule

// File: rtl/bq_fifo.sv
module bq_fifo
  import bq_pkg::*;
#(
  parameter int DEPTH = 64,
  parameter int WIDTH = 32,
  localparam int AW = $clog2(DEPTH),
  localparam int CW = $clog2(DEPTH + 1)
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             push,
  input  logic [WIDTH-1:0] pushData,
  input  logic             commit,
  input  logic             pop,
  output logic [WIDTH-1:0] popData,
  output logic             underflow,
  input  logic             clear,
  input  logic [AW-1:0]    peekSlot,
  output logic [WIDTH-1:0] peekData,
  output logic [15:0]      statusHalf,
  output logic [15:0]      cursorHalf
);
  bqStrobes_t    strobes;
  logic [AW-1:0] shadowPtr, wrPtr, rdPtr;
  logic [CW-1:0] visCount;
  logic          isEmpty, isFull;

  bq_ctrl #(.DEPTH(DEPTH)) ctrl (
    .clk(clk), .rstN(rstN), .push(push), .commit(commit), .pop(pop),
    .clear(clear), .strobes(strobes), .shadowPtr(shadowPtr), .wrPtr(wrPtr),
    .rdPtr(rdPtr), .visCount(visCount), .underflow(underflow)
  );

  bq_data #(.DEPTH(DEPTH), .WIDTH(WIDTH)) data (
    .clk(clk), .strobes(strobes), .wrAddr(shadowPtr), .wrData(pushData),
    .rdAddr(rdPtr), .peekAddr(peekSlot), .rdData(popData), .peekData(peekData)
  );

  assign isEmpty    = (visCount == '0);
  assign isFull     = (visCount == CW'(DEPTH));
  assign statusHalf = {6'b0, isFull, isEmpty, 8'(visCount)};
  assign cursorHalf = {8'(rdPtr), 8'(wrPtr)};

  // R6
  flags_exclusive_chk: assert property (@(posedge clk) disable iff (!rstN)
    !(statusHalf[8] && statusHalf[9]));
endmodule

// File: tb/bq_fifo_test.sv
module bq_fifo_test;
  localparam int CLK_PERIOD = 10;
  localparam int NVEC = 12;
  // vector: {op[1:0], data[31:0], expCount[7:0]}; op 0 push, 1 commit, 2 pop (data = expected)
  localparam logic [41:0] VECS [NVEC] = '{
    {2'd0, 32'hA1A1_0001, 8'd0}, {2'd0, 32'hA1A1_0002, 8'd0},
    {2'd1, 32'h0,         8'd2}, {2'd2, 32'hA1A1_0001, 8'd1},
    {2'd0, 32'hB2B2_0001, 8'd1}, {2'd1, 32'h0,         8'd2},
    {2'd2, 32'hA1A1_0002, 8'd1}, {2'd2, 32'hB2B2_0001, 8'd0},
    {2'd0, 32'hC3C3_0001, 8'd0}, {2'd0, 32'hC3C3_0002, 8'd0},
    {2'd0, 32'hC3C3_0003, 8'd0}, {2'd1, 32'h0,         8'd3}
  };

  logic clk = 0, rstN = 0;
  logic push = 0, commit = 0, pop = 0, clear = 0;
  logic [31:0] pushData = '0;
  logic [5:0]  peekSlot = '0;
  logic [31:0] popData, peekData;
  logic        underflow;
  logic [15:0] statusHalf, cursorHalf;
  int checks = 0, errors = 0;
  logic [31:0] seenPop;
  logic        seenUf;

  bq_fifo uut (
    .clk(clk), .rstN(rstN), .push(push), .pushData(pushData), .commit(commit),
    .pop(pop), .popData(popData), .underflow(underflow), .clear(clear),
    .peekSlot(peekSlot), .peekData(peekData), .statusHalf(statusHalf),
    .cursorHalf(cursorHalf)
  );

  always #(CLK_PERIOD/2) clk = ~clk;

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  // drive after a falling edge, capture comb outputs, hold through the rising edge
  task automatic step(input logic p, input logic [31:0] d, input logic c,
                      input logic q, input logic clr);
    push = p; pushData = d; commit = c; pop = q; clear = clr;
    #1;
    seenPop = popData; seenUf = underflow;
    @(negedge clk);
    push = 0; commit = 0; pop = 0; clear = 0;
  endtask

  function automatic logic [15:0] stat(input int n);
    return {6'b0, n == 64, n == 0, 8'(n)};
  endfunction

  initial begin
    #(CLK_PERIOD * 100000);
    errors++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    repeat (2) @(negedge clk);
    rstN = 1;
    @(negedge clk);
    check("R1 status", 32'(statusHalf), 32'(stat(0)));
    check("R1 cursors", 32'(cursorHalf), 32'h0);

    for (int i = 0; i < NVEC; i++) begin
      logic [1:0] op; logic [31:0] d; logic [7:0] ec;
      {op, d, ec} = VECS[i];
      if (op == 2'd2) begin
        step(0, 0, 0, 1, 0);
        check("R4 pop order", seenPop, d);
      end else begin
        step(op == 2'd0, d, op == 2'd1, 0, 0);
      end
      check(op == 2'd0 ? "R2 pending hidden" : "R3/R6 visible count",
            32'(statusHalf), 32'(stat(int'(ec))));
    end

    // slots: A1@0 A2@1 B1@2 C1@3 C2@4 C3@5, rd=3 wr=6
    check("R7 cursors", 32'(cursorHalf), 32'h0306);
    peekSlot = 6'd4; #1;
    check("R10 peek value", peekData, 32'hC3C3_0002);
    @(negedge clk);
    check("R10 peek no move", 32'(cursorHalf), 32'h0306);
    check("R4 head", popData, 32'hC3C3_0001);

    step(1, 32'hD4D4_0001, 1, 0, 0);
    check("R3 same-cycle commit", 32'(statusHalf), 32'(stat(4)));

    step(1, 32'hE5E5_0001, 0, 0, 0);
    check("R2 write cursor ignores pending", 32'(cursorHalf), 32'h0307);
    step(1, 32'hE5E5_0002, 1, 1, 1);
    check("R9 clear status", 32'(statusHalf), 32'(stat(0)));
    check("R9 clear cursors", 32'(cursorHalf), 32'h0);
    step(0, 0, 1, 0, 0);
    check("R9 pending discarded", 32'(statusHalf), 32'(stat(0)));

    step(0, 0, 0, 1, 0);
    check("R5 empty pop data", seenPop, 32'h0);
    check("R5 underflow", 32'(seenUf), 32'h1);
    check("R5 cursors kept", 32'(cursorHalf), 32'h0);

    for (int i = 0; i < 64; i++) step(1, 32'h1000_0000 + i, 0, 0, 0);
    step(1, 32'hDEAD_BEEF, 1, 0, 0);
    check("R8 full status", 32'(statusHalf), 32'(stat(64)));
    check("R7 equal cursors when full", 32'(cursorHalf), 32'h0);
    for (int i = 0; i < 64; i++) begin
      step(0, 0, 0, 1, 0);
      check("R8/R4 full drain", seenPop, 32'h1000_0000 + i);
    end
    check("R7 wrapped cursors", 32'(cursorHalf), 32'h0);
    check("R8 drained status", 32'(statusHalf), 32'(stat(0)));
    check("R8 dropped word absent", popData, 32'h0);

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule